// File: doc/BRIEF.md
# Logarithmic Conditional-Sum Adder

This block adds two 64-bit operands and a carry-in with no clock and no state. Its carry resolves through a binary tree of 2-to-1 multiplexers, so the depth grows with the logarithm of the width rather than linearly. The bottom level works on single bit positions. Each position produces a sum bit and a carry for both possible incoming carries.

Each level above the bottom joins neighbouring blocks in pairs, so the block width doubles at every level. When two blocks are joined, the lower block's carry for a given variant chooses which precomputed version of the upper block applies. Six such levels take the 1-bit blocks to one 64-bit block that still holds two variants. The external carry-in then picks one of them. The result is ready after about six multiplexer delays plus the bit-level logic. A multiplier's final two-operand stage, or any wide datapath that needs a short carry path, can instantiate it directly.

Top module: `condsum_adder`

## Requirements
- R1: For any operands and carry-in, the concatenation {carryOut, sum} equals the 65-bit arithmetic value opA + opB + carryIn.
- R2: With carryIn = 0, the outputs equal opA + opB. All-zero operands give sum 0 and carryOut 0.
- R3: opA all ones, opB zero and carryIn 1 make a carry ripple through all 64 positions, giving sum 0 and carryOut 1.
- R4: opA all ones, opB = 1 and carryIn 0 give sum 0 and carryOut 1.
- R5: Zero operands with carryIn 1 give sum 1 and carryOut 0.
- R6: At every level, each block's carry-1 variant {carry, sum} equals its carry-0 variant plus one. A block's carry-0 carry implies its carry-1 carry.
- R7: The block is purely combinational. A change on the inputs shows on the outputs within the same clock period, with no register on the way.
- R8: carryOut is 1 exactly when the true sum is at least 2^64. For example, 2^63 + 2^63 gives sum 0 and carryOut 1, and all ones + all ones + 1 gives sum all ones and carryOut 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 64 | First operand |
| opB | input | 64 | Second operand |
| carryIn | input | 1 | Incoming carry; picks the final variant |
| sum | output | 64 | Low 64 bits of the result |
| carryOut | output | 1 | Carry out of the most significant position |

## Verification
Carry-in selection at the top of the tree and a full-length propagate chain through every merge level can act in the same evaluation. The case that provokes both is an all-ones operand with a zero operand and carryIn = 1: each of the six levels must take its carry-1 variant, and the final multiplexer must then choose that variant as well. The bench drives this case and the neighbouring vectors (all ones plus 1, all ones plus all ones plus 1). It judges each one against a behavioural 65-bit sum computed from the operands alone. Random operand pairs with both carry-in values fill in the general case.

// File: rtl/csa_pkg.sv
package csa_pkg;
  // ceiling log2 of a positive count
  function automatic int csaLog2(input int n);
    int r;
    r = 0;
    while ((1 << r) < n) r++;
    return r;
  endfunction
endpackage

// File: rtl/csa_leaf.sv
module csa_leaf #(
  parameter int W = 64
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] s0,
  output logic [W-1:0] s1,
  output logic [W-1:0] c0,
  output logic [W-1:0] c1
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic halfSum;
    assign halfSum = a[i] ^ b[i];
    assign s0[i]   = halfSum;
    assign c0[i]   = a[i] & b[i];
    assign s1[i]   = ~halfSum;
    assign c1[i]   = a[i] | b[i];

    always_comb begin
      if (!$isunknown({c0[i], s0[i], c1[i], s1[i]})) begin
        // R6
        leaf_pair_chk: assert ({c1[i], s1[i]} == ({c0[i], s0[i]} + 2'd1))
          else $error("leaf variant pair broken at bit %0d", i);
      end
    end
  end
endmodule

// File: rtl/csa_merge.sv
module csa_merge #(
  parameter int W   = 64,
  parameter int BLK = 1
) (
  input  logic [W-1:0]       s0In,
  input  logic [W-1:0]       s1In,
  input  logic [W/BLK-1:0]   c0In,
  input  logic [W/BLK-1:0]   c1In,
  output logic [W-1:0]       s0Out,
  output logic [W-1:0]       s1Out,
  output logic [W/BLK/2-1:0] c0Out,
  output logic [W/BLK/2-1:0] c1Out
);
  localparam int NOUT = W / BLK / 2;
  localparam int OBLK = 2 * BLK;
  localparam int OW   = OBLK + 1;

  for (genvar j = 0; j < NOUT; j++) begin : g_blk
    localparam int LO = j * OBLK;
    localparam int HI = LO + BLK;
    logic selLo0, selLo1;
    assign selLo0 = c0In[2*j];
    assign selLo1 = c1In[2*j];

    assign s0Out[LO +: BLK] = s0In[LO +: BLK];
    assign s1Out[LO +: BLK] = s1In[LO +: BLK];
    assign s0Out[HI +: BLK] = selLo0 ? s1In[HI +: BLK] : s0In[HI +: BLK];
    assign s1Out[HI +: BLK] = selLo1 ? s1In[HI +: BLK] : s0In[HI +: BLK];
    assign c0Out[j] = selLo0 ? c1In[2*j+1] : c0In[2*j+1];
    assign c1Out[j] = selLo1 ? c1In[2*j+1] : c0In[2*j+1];

    always_comb begin
      if (!$isunknown({c0Out[j], c1Out[j], s0Out[LO +: OBLK], s1Out[LO +: OBLK]})) begin
        // R6
        merge_pair_chk: assert ({c1Out[j], s1Out[LO +: OBLK]} ==
                                ({c0Out[j], s0Out[LO +: OBLK]} + OW'(1)))
          else $error("merged variant pair broken, block %0d width %0d", j, OBLK);
        // R6
        carry_order_chk: assert (!c0Out[j] || c1Out[j])
          else $error("carry-0 variant set without carry-1 variant, block %0d", j);
      end
    end
  end
endmodule

// File: rtl/csa_select.sv
module csa_select #(
  parameter int W = 64
) (
  input  logic [W-1:0] s0,
  input  logic [W-1:0] s1,
  input  logic         c0,
  input  logic         c1,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  assign sum  = cin ? s1 : s0;
  assign cout = cin ? c1 : c0;
endmodule

// File: rtl/condsum_adder.sv
module condsum_adder
  import csa_pkg::*;
#(
  parameter int W = 64
) (
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic         carryIn,
  output logic [W-1:0] sum,
  output logic         carryOut
);
  localparam int LEVELS = csaLog2(W);

  for (genvar l = 0; l <= LEVELS; l++) begin : g_lvl
    localparam int NB = W >> l;
    logic [W-1:0]  s0, s1;
    logic [NB-1:0] c0, c1;
    if (l == 0) begin : g_leaf
      csa_leaf #(.W(W)) u_leaf (
        .a(opA), .b(opB), .s0(s0), .s1(s1), .c0(c0), .c1(c1)
      );
    end else begin : g_join
      csa_merge #(.W(W), .BLK(1 << (l - 1))) u_merge (
        .s0In(g_lvl[l-1].s0), .s1In(g_lvl[l-1].s1),
        .c0In(g_lvl[l-1].c0), .c1In(g_lvl[l-1].c1),
        .s0Out(s0), .s1Out(s1), .c0Out(c0), .c1Out(c1)
      );
    end
  end

  csa_select #(.W(W)) u_sel (
    .s0(g_lvl[LEVELS].s0), .s1(g_lvl[LEVELS].s1),
    .c0(g_lvl[LEVELS].c0[0]), .c1(g_lvl[LEVELS].c1[0]),
    .cin(carryIn), .sum(sum), .cout(carryOut)
  );

  always_comb begin
    if (!$isunknown({opA, opB, carryIn, sum, carryOut})) begin
      // R1
      total_sum_chk: assert ({carryOut, sum} ==
                             ({1'b0, opA} + {1'b0, opB} + {{W{1'b0}}, carryIn}))
        else $error("adder result disagrees with operands");
    end
  end
endmodule

// File: tb/condsum_adder_tb.sv
module condsum_adder_tb;
  localparam int W = 64;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [W-1:0] opA = '0, opB = '0;
  logic carryIn = 1'b0;
  logic [W-1:0] sum;
  logic carryOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  condsum_adder #(.W(W)) u_dut (
    .opA(opA), .opB(opB), .carryIn(carryIn), .sum(sum), .carryOut(carryOut)
  );

  localparam logic [W-1:0] ONES = '1;

  // behavioural reference: plain wide addition
  task automatic judge(input string req);
    logic [W:0] expv;
    expv = {1'b0, opA} + {1'b0, opB} + {{W{1'b0}}, carryIn};
    checks++;
    if ({carryOut, sum} !== expv) begin
      errors++;
      $display("FAIL %s: got cout=%0b sum=%h, expected cout=%0b sum=%h",
               req, carryOut, sum, expv[W], expv[W-1:0]);
    end
  endtask

  task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic ci, input string req);
    @(posedge clk);
    #1;
    opA = a; opB = b; carryIn = ci;
    @(negedge clk);
    judge(req);
  endtask

  task automatic expectExact(input logic [W-1:0] s, input logic co, input string req);
    checks++;
    if (sum !== s || carryOut !== co) begin
      errors++;
      $display("FAIL %s: got cout=%0b sum=%h, expected cout=%0b sum=%h",
               req, carryOut, sum, co, s);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state: zero inputs, R2
    expectExact('0, 1'b0, "R2 reset zero");

    apply('0, '0, 1'b1, "R5");
    expectExact(64'd1, 1'b0, "R5 exact");
    apply(ONES, '0, 1'b1, "R3");
    expectExact('0, 1'b1, "R3 exact");
    apply(ONES, 64'd1, 1'b0, "R4");
    expectExact('0, 1'b1, "R4 exact");
    apply(64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b0, "R8");
    expectExact('0, 1'b1, "R8 msb pair");
    apply(ONES, ONES, 1'b1, "R8");
    expectExact(ONES, 1'b1, "R8 all ones");
    apply(64'h0123_4567_89ab_cdef, 64'hfedc_ba98_7654_3210, 1'b0, "R2");
    apply(64'h0123_4567_89ab_cdef, 64'hfedc_ba98_7654_3210, 1'b1, "R8");
    apply(64'h5555_5555_5555_5555, 64'haaaa_aaaa_aaaa_aaaa, 1'b1, "R6");
    apply(64'h0000_0000_ffff_ffff, 64'h0000_0000_0000_0001, 1'b0, "R6");
    apply(64'h7fff_ffff_ffff_ffff, 64'd0, 1'b1, "R6");

    // R7: change inputs mid-period and look again within the same period
    @(posedge clk);
    #1; opA = 64'd40; opB = 64'd2; carryIn = 1'b0;
    #1; expectExact(64'd42, 1'b0, "R7 first");
    opA = ONES; opB = 64'd5;
    #1; expectExact(64'd4, 1'b1, "R7 second");

    // R1: random operands with both carry-in values
    for (int i = 0; i < 3000; i++) begin
      apply({$urandom, $urandom}, {$urandom, $urandom}, 1'($urandom), "R1");
    end
    // R2: random with carry-in forced low
    for (int i = 0; i < 500; i++) begin
      apply({$urandom, $urandom}, {$urandom, $urandom}, 1'b0, "R2");
    end
    // R6: long propagate runs of random length
    for (int i = 0; i < 500; i++) begin
      int k;
      logic [W-1:0] runv;
      k = int'($urandom % 64);
      runv = ONES >> k;
      apply(runv, '0, 1'b1, "R6");
      apply(runv, 64'd1, 1'b0, "R6");
    end
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 100000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got run still busy, expected completion");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule